// File: doc/BRIEF.md
# Pipelined Max-Log LLR Unit

This block forms the soft output of one trellis step in a max-log soft-in soft-out decoder. Each cycle it takes the forward metrics of the previous step, the backward metrics of the current step and one branch metric for every trellis transition. It adds these three into a path sum for each transition. It then reduces the sums that assume a decoded bit of 1 and the sums that assume a decoded bit of 0, each to its own maximum, and reports their difference as a log-likelihood ratio together with a hard bit decision.

The trellis has NS states, with NS a power of two. Source state s with hypothesis bit b moves to state (b << (log2(NS)-1)) | (s >> 1). The compare-select tree is cut by registers: one stage for the additions, one stage per tree level, and one stage for the final subtraction and clamp. A new step can therefore enter on every cycle, and the result leaves at a fixed latency. The block also reports the source state of the winning transition for each hypothesis. When path sums are equal, the lowest-numbered source state wins, so these outputs are deterministic.

There is no state machine. The only sequencing is a valid bit that travels alongside the data in the pipeline.

Top module: `max_log_llr`

## Requirements
- R1: For hypothesis b (0 or 1) and source state s, the path sum is alpha[s] + gamma[b*NS + s] + beta[(b << (log2(NS)-1)) | (s >> 1)]. Element j of each packed metric input occupies bits [j*MW +: MW] as a two's-complement value.
- R2: Before clamping, the LLR equals the largest path sum for b = 1 minus the largest path sum for b = 0, computed without internal overflow.
- R3: llr_o is a two's-complement LW-bit value, clamped to the range [-2^(LW-1), 2^(LW-1)-1] (-128..127 by default) rather than wrapped.
- R4: hard_o is 1 when the unclamped LLR is strictly positive. It is 0 when the LLR is zero or negative.
- R5: win0_o and win1_o give the source state of the largest path sum for b = 0 and b = 1 respectively. On equal sums, the lowest-numbered source state is chosen.
- R6: A step sampled on a rising edge with in_valid high appears on the outputs after the fifth rising edge, counting the sampling edge (log2(NS) + 2 edges in general). A new step may be accepted on every edge.
- R7: out_valid is high exactly for the results of steps sampled with in_valid high. Idle input cycles come out as idle output cycles in the same order.
- R8: While rst_n is low (asynchronous, active low), out_valid, llr_o, hard_o, win0_o and win1_o are all zero.
- R9: While out_valid is low, llr_o, hard_o, win0_o and win1_o hold the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Metrics on the inputs form a step to decode |
| alpha_i | input | NS*MW (80) | Forward metrics of the previous step, one per source state |
| beta_i | input | NS*MW (80) | Backward metrics of the current step, one per destination state |
| gamma_i | input | 2*NS*MW (160) | Branch metrics; entries 0..NS-1 are for bit 0, entries NS..2NS-1 are for bit 1, each indexed by source state |
| out_valid | output | 1 | A result is present on the outputs |
| llr_o | output | LW (8) | Clamped log-likelihood ratio |
| hard_o | output | 1 | Hard decision bit |
| win0_o | output | log2(NS) (3) | Winning source state for bit 0 |
| win1_o | output | log2(NS) (3) | Winning source state for bit 1 |

## Verification
Small random metrics exercise ordinary LLR values. Full-range random metrics exercise the extra internal width. Metrics biased towards one hypothesis drive the output into the positive and negative clamps. Vectors where only one backward metric is non-zero separate a correct successor-state mapping from a wrong one, because only the transitions that reach that state can win. Vectors with all path sums equal, or with two equal maxima at chosen states, separate lowest-index tie breaking from any other rule. Directed differences of exactly 127, 128, -128 and -129 locate the clamp boundary. A table mixing back-to-back steps with idle cycles checks latency, bubble ordering and holding of the outputs.

// File: rtl/llr_pkg.sv
package llr_pkg;

    // Successor state for a shift-register trellis: hypothesis bit enters at the top.
    function automatic int succ_state(int src, int hyp, int sw);
        return (hyp << (sw - 1)) | (src >> 1);
    endfunction

endpackage

// File: rtl/llr_cand_add.sv
module llr_cand_add
    import llr_pkg::*;
#(
    parameter int NS = 8,
    parameter int MW = 10,
    parameter int CW = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid_i,
    input  logic [NS-1:0][MW-1:0]       alpha_i,
    input  logic [NS-1:0][MW-1:0]       beta_i,
    input  logic [2*NS-1:0][MW-1:0]     gamma_i,
    output logic                        valid_o,
    output logic [2*NS-1:0][CW-1:0]     cand_o
);
    localparam int SW = $clog2(NS);

    logic [2*NS-1:0][CW-1:0] sum_c;

    function automatic logic [CW-1:0] ext(logic [MW-1:0] v);
        return {{(CW - MW){v[MW-1]}}, v};
    endfunction

    always_comb begin
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < NS; s++) begin
                int t;
                int nxt;
                t = b * NS + s;
                nxt = succ_state(s, b, SW);
                sum_c[t] = ext(alpha_i[s]) + ext(gamma_i[t]) + ext(beta_i[nxt]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            cand_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                cand_o <= sum_c;
            end
        end
    end

endmodule

// File: rtl/llr_cs_level.sv
module llr_cs_level #(
    parameter int N  = 16,
    parameter int CW = 12,
    parameter int XW = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_i,
    input  logic [N-1:0][CW-1:0]      val_i,
    input  logic [N-1:0][XW-1:0]      idx_i,
    output logic                      valid_o,
    output logic [N/2-1:0][CW-1:0]    val_o,
    output logic [N/2-1:0][XW-1:0]    idx_o
);
    localparam int NO = N / 2;

    logic [NO-1:0] take_hi;

    always_comb begin
        for (int p = 0; p < NO; p++) begin
            take_hi[p] = $signed(val_i[2*p+1]) > $signed(val_i[2*p]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            val_o   <= '0;
            idx_o   <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                for (int p = 0; p < NO; p++) begin
                    val_o[p] <= take_hi[p] ? val_i[2*p+1] : val_i[2*p];
                    idx_o[p] <= take_hi[p] ? idx_i[2*p+1] : idx_i[2*p];
                end
            end
        end
    end

    genvar gp;
    generate
        for (gp = 0; gp < NO; gp++) begin : g_pair
            // R5
            tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_i && (val_i[2*gp] == val_i[2*gp+1])) |=> (idx_o[gp] == $past(idx_i[2*gp])));
        end
    endgenerate

endmodule

// File: rtl/llr_finalize.sv
module llr_finalize #(
    parameter int CW = 12,
    parameter int LW = 8,
    parameter int XW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [CW-1:0]   m0_i,
    input  logic [CW-1:0]   m1_i,
    input  logic [XW-1:0]   x0_i,
    input  logic [XW-1:0]   x1_i,
    output logic            valid_o,
    output logic [LW-1:0]   llr_o,
    output logic            hard_o,
    output logic [XW-1:0]   win0_o,
    output logic [XW-1:0]   win1_o
);
    localparam int DW   = CW + 1;
    localparam int MAXV = (1 << (LW - 1)) - 1;
    localparam int MINV = -(1 << (LW - 1));

    logic [DW-1:0] diff;
    logic          over_hi;
    logic          under_lo;
    logic          positive;
    logic [LW-1:0] clamped;

    always_comb begin
        diff     = {m1_i[CW-1], m1_i} - {m0_i[CW-1], m0_i};
        over_hi  = $signed(diff) > $signed(DW'(MAXV));
        under_lo = $signed(diff) < $signed(DW'(MINV));
        positive = !diff[DW-1] && (diff != '0);
        if (over_hi) begin
            clamped = LW'(MAXV);
        end else if (under_lo) begin
            clamped = LW'(MINV);
        end else begin
            clamped = diff[LW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            llr_o   <= '0;
            hard_o  <= 1'b0;
            win0_o  <= '0;
            win1_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                llr_o  <= clamped;
                hard_o <= positive;
                win0_o <= x0_i;
                win1_o <= x1_i;
            end
        end
    end

    // R3
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && over_hi) |=> (llr_o == LW'(MAXV)));

    // R3
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && under_lo) |=> (llr_o == LW'(MINV)));

    // R4
    bit_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (hard_o == ($signed(llr_o) > 0)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(llr_o) && $stable(hard_o) && $stable(win0_o) && $stable(win1_o)));

endmodule

// File: rtl/max_log_llr.sv
module max_log_llr #(
    parameter int NS = 8,
    parameter int MW = 10,
    parameter int LW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NS*MW-1:0]        alpha_i,
    input  logic [NS*MW-1:0]        beta_i,
    input  logic [2*NS*MW-1:0]      gamma_i,
    output logic                    out_valid,
    output logic [LW-1:0]           llr_o,
    output logic                    hard_o,
    output logic [$clog2(NS)-1:0]   win0_o,
    output logic [$clog2(NS)-1:0]   win1_o
);
    localparam int SW     = $clog2(NS);
    localparam int CW     = MW + 2;
    localparam int LEVELS = SW;
    localparam int LAT    = LEVELS + 2;
    localparam int CNTW   = $clog2(LAT + 1);

    logic [NS-1:0][MW-1:0]   alpha_a;
    logic [NS-1:0][MW-1:0]   beta_a;
    logic [2*NS-1:0][MW-1:0] gamma_a;

    assign alpha_a = alpha_i;
    assign beta_a  = beta_i;
    assign gamma_a = gamma_i;

    logic                    cand_valid;
    logic [2*NS-1:0][CW-1:0] cand;
    logic [2*NS-1:0][SW-1:0] cand_idx;

    llr_cand_add #(.NS(NS), .MW(MW), .CW(CW)) u_add (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .alpha_i (alpha_a),
        .beta_i  (beta_a),
        .gamma_i (gamma_a),
        .valid_o (cand_valid),
        .cand_o  (cand)
    );

    genvar gt;
    generate
        for (gt = 0; gt < 2 * NS; gt++) begin : g_idx
            assign cand_idx[gt] = SW'(gt % NS);
        end
    endgenerate

    genvar gl;
    generate
        for (gl = 0; gl < LEVELS; gl++) begin : g_lvl
            localparam int NI = (2 * NS) >> gl;
            localparam int NO = NI / 2;
            logic                vin_ok;
            logic [NI-1:0][CW-1:0] vin;
            logic [NI-1:0][SW-1:0] xin;
            logic                vout_ok;
            logic [NO-1:0][CW-1:0] vout;
            logic [NO-1:0][SW-1:0] xout;

            if (gl == 0) begin : g_first
                assign vin_ok = cand_valid;
                assign vin    = cand;
                assign xin    = cand_idx;
            end else begin : g_next
                assign vin_ok = g_lvl[gl-1].vout_ok;
                assign vin    = g_lvl[gl-1].vout;
                assign xin    = g_lvl[gl-1].xout;
            end

            llr_cs_level #(.N(NI), .CW(CW), .XW(SW)) u_cs (
                .clk     (clk),
                .rst_n   (rst_n),
                .valid_i (vin_ok),
                .val_i   (vin),
                .idx_i   (xin),
                .valid_o (vout_ok),
                .val_o   (vout),
                .idx_o   (xout)
            );
        end
    endgenerate

    llr_finalize #(.CW(CW), .LW(LW), .XW(SW)) u_fin (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (g_lvl[LEVELS-1].vout_ok),
        .m0_i    (g_lvl[LEVELS-1].vout[0]),
        .m1_i    (g_lvl[LEVELS-1].vout[1]),
        .x0_i    (g_lvl[LEVELS-1].xout[0]),
        .x1_i    (g_lvl[LEVELS-1].xout[1]),
        .valid_o (out_valid),
        .llr_o   (llr_o),
        .hard_o  (hard_o),
        .win0_o  (win0_o),
        .win1_o  (win1_o)
    );

    logic [CNTW-1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != CNTW'(LAT)) begin
            since_rst <= since_rst + CNTW'(1);
        end
    end

    // R6 R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == CNTW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && (llr_o == '0) && !hard_o && (win0_o == '0) && (win1_o == '0)));

endmodule

// File: tb/tb_max_log_llr.sv
module tb_max_log_llr;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int MW = 10;
    localparam int LW = 8;
    localparam int SW = 3;
    localparam int NV = 12;

    // stimulus table: pattern kind, seed, in_valid
    // kinds: 0 zero, 1 small random, 2 full random, 3 bias to one, 4 bias to zero, 5 all equal, 6 ramp
    localparam int KIND [NV] = '{1, 2, 0, 3, 4, 5, 6, 2, 1, 3, 2, 1};
    localparam int SEED [NV] = '{11, 23, 5, 77, 91, 3, 8, 140, 301, 55, 999, 42};
    localparam bit TVAL [NV] = '{1, 1, 0, 1, 1, 1, 0, 1, 1, 0, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NS*MW-1:0] alpha_i = '0;
    logic [NS*MW-1:0] beta_i = '0;
    logic [2*NS*MW-1:0] gamma_i = '0;
    logic out_valid;
    logic [LW-1:0] llr_o;
    logic hard_o;
    logic [SW-1:0] win0_o;
    logic [SW-1:0] win1_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    max_log_llr #(.NS(NS), .MW(MW), .LW(LW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .alpha_i   (alpha_i),
        .beta_i    (beta_i),
        .gamma_i   (gamma_i),
        .out_valid (out_valid),
        .llr_o     (llr_o),
        .hard_o    (hard_o),
        .win0_o    (win0_o),
        .win1_o    (win1_o)
    );

    int al [NS];
    int be [NS];
    int ga [2*NS];
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int unsigned st = 0;

    bit sv [8];
    int sl [8];
    int sraw [8];
    bit sb [8];
    int s0 [8];
    int s1 [8];
    bit mon_on = 1'b0;
    bit have_last = 1'b0;
    int last_llr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        st = st * 32'd1103515245 + 32'd12345;
        return lo + int'((st >> 8) % unsigned'(hi - lo + 1));
    endfunction

    function automatic int sat(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic clear_metrics();
        for (int s = 0; s < NS; s++) begin
            al[s] = 0;
            be[s] = 0;
        end
        for (int t = 0; t < 2 * NS; t++) ga[t] = 0;
    endtask

    task automatic gen(input int kind, input int seed);
        st = seed;
        clear_metrics();
        for (int s = 0; s < NS; s++) begin
            case (kind)
                1: begin al[s] = rnd(-40, 40); be[s] = rnd(-40, 40); end
                2: begin al[s] = rnd(-512, 511); be[s] = rnd(-512, 511); end
                3, 4: begin al[s] = rnd(-20, 20); be[s] = rnd(-20, 20); end
                5: begin al[s] = 7; be[s] = 7; end
                6: begin al[s] = s * 10; be[s] = -s * 5; end
                default: ;
            endcase
        end
        for (int t = 0; t < 2 * NS; t++) begin
            case (kind)
                1: ga[t] = rnd(-40, 40);
                2: ga[t] = rnd(-512, 511);
                3: ga[t] = (t >= NS) ? rnd(400, 500) : rnd(-500, -400);
                4: ga[t] = (t >= NS) ? rnd(-500, -400) : rnd(400, 500);
                5: ga[t] = 3;
                6: ga[t] = t * 3 - 20;
                default: ;
            endcase
        end
    endtask

    // Reference from R1, R2, R5: successor = (b << 2) | (s >> 1), lowest source wins ties
    task automatic model(output int raw, output int w0, output int w1);
        int best [2];
        int idx [2];
        for (int b = 0; b < 2; b++) begin
            best[b] = -100000;
            idx[b] = 0;
            for (int s = 0; s < NS; s++) begin
                int c;
                c = al[s] + ga[b * NS + s] + be[b * (NS / 2) + s / 2];
                if (c > best[b]) begin
                    best[b] = c;
                    idx[b] = s;
                end
            end
        end
        raw = best[1] - best[0];
        w0 = idx[0];
        w1 = idx[1];
    endtask

    task automatic step(input bit v);
        int raw;
        int w0;
        int w1;
        int k;
        @(negedge clk);
        k = cyc % 8;
        in_valid = v;
        for (int s = 0; s < NS; s++) begin
            alpha_i[s*MW +: MW] = MW'(al[s]);
            beta_i[s*MW +: MW] = MW'(be[s]);
        end
        for (int t = 0; t < 2 * NS; t++) gamma_i[t*MW +: MW] = MW'(ga[t]);
        if (v) begin
            model(raw, w0, w1);
            sv[k] = 1'b1;
            sraw[k] = raw;
            sl[k] = sat(raw);
            sb[k] = (raw > 0);
            s0[k] = w0;
            s1[k] = w1;
        end else begin
            sv[k] = 1'b0;
        end
    endtask

    // Output monitor: result of the step driven 5 edges earlier (R6)
    always @(negedge clk) begin
        if (mon_on) begin
            int k;
            k = (cyc + 3) % 8;
            chk("R6/R7 out_valid", int'(out_valid), int'(sv[k]));
            if (sv[k]) begin
                if (sraw[k] > 127 || sraw[k] < -128)
                    chk("R3 clamped llr", int'($signed(llr_o)), sl[k]);
                else
                    chk("R1/R2 llr", int'($signed(llr_o)), sl[k]);
                chk("R4 hard bit", int'(hard_o), int'(sb[k]));
                chk("R5 winner for bit 0", int'(win0_o), s0[k]);
                chk("R5 winner for bit 1", int'(win1_o), s1[k]);
                have_last = 1'b1;
                last_llr = sl[k];
            end else if (have_last) begin
                chk("R9 llr held", int'($signed(llr_o)), last_llr);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) sv[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R8: outputs cleared during reset
        chk("R8 out_valid in reset", int'(out_valid), 0);
        chk("R8 llr in reset", int'(llr_o), 0);
        chk("R8 hard in reset", int'(hard_o), 0);
        chk("R8 winners in reset", int'(win0_o) + int'(win1_o), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (3) step(1'b0);

        // table of vectors, back to back with bubbles (R6, R7)
        for (int i = 0; i < NV; i++) begin
            gen(KIND[i], SEED[i]);
            step(TVAL[i]);
        end
        repeat (3) step(1'b0);

        // R5: equal maxima at states 3 and 5 for bit 1, at 2 and 6 for bit 0
        clear_metrics();
        for (int s = 0; s < NS; s++) ga[s] = -10;
        ga[NS + 3] = 50;
        ga[NS + 5] = 50;
        ga[2] = 20;
        ga[6] = 20;
        step(1'b1);

        // R1: only backward metric of state 5 set; reached from sources 2,3 under bit 1
        clear_metrics();
        be[5] = 60;
        step(1'b1);

        // R3 boundaries: 127, 128, -128, -129
        clear_metrics();
        ga[NS] = 127;
        step(1'b1);
        clear_metrics();
        ga[NS] = 128;
        step(1'b1);
        clear_metrics();
        ga[0] = 128;
        step(1'b1);
        clear_metrics();
        ga[0] = 129;
        step(1'b1);

        // R4: zero difference gives hard bit 0
        clear_metrics();
        step(1'b1);
        repeat (8) step(1'b0);

        // R8: reset while the pipeline is busy
        gen(2, 7);
        step(1'b1);
        step(1'b1);
        step(1'b1);
        step(1'b1);
        step(1'b1);
        @(negedge clk);
        mon_on = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R8 out_valid after mid-run reset", int'(out_valid), 0);
        chk("R8 llr after mid-run reset", int'(llr_o), 0);
        chk("R8 hard after mid-run reset", int'(hard_o), 0);
        repeat (2) @(negedge clk);
        chk("R8 out_valid held in reset", int'(out_valid), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule